// File: doc/BRIEF.md
# Shadowed PWM Generator With Fine Edge

This block is one pulse-width modulation channel driven by an up-counting time base. The counter climbs from zero to a programmable terminal value and then restarts. It drives two outputs. Output A rises when the count is zero and falls at a coarse compare match. That falling edge also carries a sub-cycle fine-delay code, which a downstream delay element can use to place the edge more precisely than one clock. Output B rises when the count is zero and falls at its own compare match.

The two compare values and the fine code are written into shadow registers. They move to their active copies only on an enabled clock in which the count is zero, so a new duty cycle never takes effect partway through a period. The terminal count register has no shadow: a write reaches the counter on the very next clock. The fine code is not applied to any signal inside the block. It is published as the active code, together with a one-cycle valid pulse at each falling edge of A. No analog delay line is included.

Top module: `pwm_fine_edge_gen`

## Requirements
- R1: While `en` is high the counter advances by one per clock. On the clock after the counter holds a value greater than or equal to the terminal register, it returns to 0. A period therefore lasts (terminal + 1) clocks, and software writes the desired period minus 1.
- R2: A write on `prd_wr` updates the terminal register on the next clock, with no shadow stage. A counter already above the new terminal wraps to 0 on the following enabled clock.
- R3: Compare A and compare B writes land in shadow registers. A shadow value moves to the active compare only on an enabled clock in which the counter is 0. A write made on that same clock waits for the next zero.
- R4: Each output is registered and shows the action for the count of the previous enabled clock. For output A, count 0 drives it high and a count equal to the active compare A (nonzero count) drives it low. Otherwise it holds, so with a steady compare it is high for exactly compare-A clocks per period.
- R5: Output B follows the same rule with compare B, and its high time per period equals compare B.
- R6: `fine_wdata` is the upper byte of the 16-bit fine-extension register, so value 0x44 written there means code 0x44. It is shadowed and moves to `fine_code` only at counter zero, together with the coarse compares.
- R7: `fine_valid` is a one-cycle pulse on the same clock on which `pwm_a` goes from high to low, and `fine_code` then holds the code in force for that edge. It never pulses at any other time.
- R8: After synchronous reset: counter 0, terminal = INIT_PERIOD-1 (29 by default), both compares = INIT_PERIOD/2 (15), fine code = 1, `pwm_a` = `pwm_b` = 0, `fine_valid` = 0.
- R9: A compare of 0 keeps its output low for the whole period. A compare greater than the terminal keeps it high for the whole period. Neither case produces a pulse.
- R10: While `en` is low the counter, both outputs and the active registers hold, and `fine_valid` stays low. Shadow and terminal writes are still accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Time-base run enable |
| prd_wr | input | 1 | Terminal count write strobe |
| prd_wdata | input | CNT_W | Terminal count (period minus 1) |
| cmpa_wr | input | 1 | Compare A shadow write strobe |
| cmpa_wdata | input | CNT_W | Compare A value |
| cmpb_wr | input | 1 | Compare B shadow write strobe |
| cmpb_wdata | input | CNT_W | Compare B value |
| fine_wr | input | 1 | Fine code shadow write strobe |
| fine_wdata | input | FINE_W | Upper byte of the fine-extension register |
| pwm_a | output | 1 | PWM output A (fine-tagged falling edge) |
| pwm_b | output | 1 | PWM output B |
| fine_code | output | FINE_W | Active fine-delay code |
| fine_valid | output | 1 | One-cycle pulse marking the falling edge of A |

## Verification
Some rules are checked by the assertions on every clock. These are the counter wrap and increment, the immediate terminal update, the rule that active compare and fine code change only at an enabled zero, the level of A right after zero for zero and nonzero compares, the tie between `fine_valid` and an A falling edge, and the freeze while disabled. Other behaviour only shows over whole periods, and the bench scenarios cover it. This includes the high time of each output and the period length after a terminal write that lands mid-period. It also includes the one-period delay of a fine code written just after zero, and a long stream of writes landing at arbitrary counts, which is checked clock by clock against the bench model.

// File: rtl/pwm_fe_pkg.sv
package pwm_fe_pkg;

  // Width of the fine-extension register as software sees it; the fine
  // code occupies its upper byte.
  localparam int unsigned HR_REG_W = 16;

  // Number of compare-driven outputs in the channel.
  localparam int unsigned NUM_CH = 2;

  // Output index; A is the one with the fine-tagged falling edge.
  typedef enum int unsigned {
    CH_A = 0,
    CH_B = 1
  } pwm_ch_e;

endpackage

// File: rtl/pwm_tb_counter.sv
// Up-counting time base with an unshadowed terminal register.
module pwm_tb_counter #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned PRD_RST = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             prd_wr,
  input  logic [CNT_W-1:0] prd_wdata,
  output logic [CNT_W-1:0] ctr_o,
  output logic [CNT_W-1:0] prd_o,
  output logic             at_zero_o
);

  logic [CNT_W-1:0] ctr_q;
  logic [CNT_W-1:0] prd_q;
  logic             wrap;

  // >= rather than == so a terminal lowered below the count still wraps.
  assign wrap = (ctr_q >= prd_q);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q <= '0;
      prd_q <= CNT_W'(PRD_RST);
    end else begin
      if (prd_wr) begin
        prd_q <= prd_wdata;
      end
      if (en) begin
        ctr_q <= wrap ? '0 : ctr_q + 1'b1;
      end
    end
  end

  assign ctr_o     = ctr_q;
  assign prd_o     = prd_q;
  assign at_zero_o = (ctr_q == '0);

endmodule

// File: rtl/pwm_shadow_pair.sv
// Shadow register plus active copy, transferred on a load strobe.
module pwm_shadow_pair #(
  parameter int unsigned W       = 16,
  parameter int unsigned RST_VAL = 0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         wr,
  input  logic [W-1:0] wdata,
  input  logic         load,
  output logic [W-1:0] shadow_o,
  output logic [W-1:0] active_o
);

  logic [W-1:0] shadow_q;
  logic [W-1:0] active_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      shadow_q <= W'(RST_VAL);
      active_q <= W'(RST_VAL);
    end else begin
      if (wr) begin
        shadow_q <= wdata;
      end
      // Load takes the shadow as it stood before any same-cycle write.
      if (load) begin
        active_q <= shadow_q;
      end
    end
  end

  assign shadow_o = shadow_q;
  assign active_o = active_q;

endmodule

// File: rtl/pwm_edge_ctl.sv
// Set-at-zero / clear-at-match action for one output, registered.
module pwm_edge_ctl #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             at_zero,
  input  logic [CNT_W-1:0] ctr,
  input  logic [CNT_W-1:0] cmp_eff,
  output logic             pwm_o
);

  logic pwm_q;
  logic pwm_d;

  always_comb begin
    if (at_zero) begin
      // Compare 0 means the clear wins over the set at the same count.
      pwm_d = (cmp_eff != '0);
    end else if (ctr == cmp_eff) begin
      pwm_d = 1'b0;
    end else begin
      pwm_d = pwm_q;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pwm_q <= 1'b0;
    end else if (en) begin
      pwm_q <= pwm_d;
    end
  end

  assign pwm_o = pwm_q;

endmodule

// File: rtl/pwm_fine_tag.sv
// Marks each high-to-low transition of output A with a one-cycle pulse.
module pwm_fine_tag #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic             at_zero,
  input  logic [CNT_W-1:0] ctr,
  input  logic [CNT_W-1:0] cmp_eff,
  input  logic             level,
  output logic             valid_o
);

  logic clear_hit;
  logic valid_q;

  // A clear action reached while the output is high is a falling edge.
  assign clear_hit = at_zero ? (cmp_eff == '0) : (ctr == cmp_eff);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
    end else begin
      valid_q <= en && level && clear_hit;
    end
  end

  assign valid_o = valid_q;

endmodule

// File: rtl/pwm_fine_edge_gen.sv
// Single PWM channel: shadowed compares, immediate terminal, fine code on A.
module pwm_fine_edge_gen
  import pwm_fe_pkg::*;
#(
  parameter int unsigned CNT_W       = 16,
  parameter int unsigned FINE_W      = 8,
  parameter int unsigned INIT_PERIOD = 30
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic              prd_wr,
  input  logic [CNT_W-1:0]  prd_wdata,
  input  logic              cmpa_wr,
  input  logic [CNT_W-1:0]  cmpa_wdata,
  input  logic              cmpb_wr,
  input  logic [CNT_W-1:0]  cmpb_wdata,
  input  logic              fine_wr,
  input  logic [FINE_W-1:0] fine_wdata,
  output logic              pwm_a,
  output logic              pwm_b,
  output logic [FINE_W-1:0] fine_code,
  output logic              fine_valid
);

  localparam int unsigned PRD_RST  = INIT_PERIOD - 1;
  localparam int unsigned CMP_RST  = INIT_PERIOD / 2;
  localparam int unsigned FINE_RST = 1;

  logic [CNT_W-1:0] ctr_q;
  logic [CNT_W-1:0] prd_q;
  logic             at_zero;
  logic             xfer;

  logic [NUM_CH-1:0] cmp_wr_v;
  logic [CNT_W-1:0]  cmp_wd  [NUM_CH];
  logic [CNT_W-1:0]  cmp_sh  [NUM_CH];
  logic [CNT_W-1:0]  cmp_act [NUM_CH];
  logic [CNT_W-1:0]  cmp_eff [NUM_CH];
  logic [NUM_CH-1:0] pwm_v;

  logic [FINE_W-1:0] fine_sh;
  logic [FINE_W-1:0] fine_act;

  pwm_tb_counter #(
    .CNT_W   (CNT_W),
    .PRD_RST (PRD_RST)
  ) u_tbase (
    .clk       (clk),
    .rst       (rst),
    .en        (en),
    .prd_wr    (prd_wr),
    .prd_wdata (prd_wdata),
    .ctr_o     (ctr_q),
    .prd_o     (prd_q),
    .at_zero_o (at_zero)
  );

  // Shadow-to-active transfer happens only on an enabled zero count.
  assign xfer = en && at_zero;

  assign cmp_wr_v[CH_A] = cmpa_wr;
  assign cmp_wr_v[CH_B] = cmpb_wr;
  assign cmp_wd[CH_A]   = cmpa_wdata;
  assign cmp_wd[CH_B]   = cmpb_wdata;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
    pwm_shadow_pair #(
      .W       (CNT_W),
      .RST_VAL (CMP_RST)
    ) u_cmp (
      .clk      (clk),
      .rst      (rst),
      .wr       (cmp_wr_v[g]),
      .wdata    (cmp_wd[g]),
      .load     (xfer),
      .shadow_o (cmp_sh[g]),
      .active_o (cmp_act[g])
    );

    // At zero the value being loaded is the one that governs this period.
    assign cmp_eff[g] = at_zero ? cmp_sh[g] : cmp_act[g];

    pwm_edge_ctl #(
      .CNT_W (CNT_W)
    ) u_edge (
      .clk     (clk),
      .rst     (rst),
      .en      (en),
      .at_zero (at_zero),
      .ctr     (ctr_q),
      .cmp_eff (cmp_eff[g]),
      .pwm_o   (pwm_v[g])
    );
  end

  pwm_shadow_pair #(
    .W       (FINE_W),
    .RST_VAL (FINE_RST)
  ) u_fine (
    .clk      (clk),
    .rst      (rst),
    .wr       (fine_wr),
    .wdata    (fine_wdata),
    .load     (xfer),
    .shadow_o (fine_sh),
    .active_o (fine_act)
  );

  pwm_fine_tag #(
    .CNT_W (CNT_W)
  ) u_tag (
    .clk     (clk),
    .rst     (rst),
    .en      (en),
    .at_zero (at_zero),
    .ctr     (ctr_q),
    .cmp_eff (cmp_eff[CH_A]),
    .level   (pwm_v[CH_A]),
    .valid_o (fine_valid)
  );

  assign pwm_a     = pwm_v[CH_A];
  assign pwm_b     = pwm_v[CH_B];
  assign fine_code = fine_act;

endmodule

// File: rtl/pwm_fine_edge_gen_chk.sv
// Property checker, attached to every pwm_fine_edge_gen instance.
module pwm_fine_edge_gen_chk #(
  parameter int unsigned CNT_W  = 16,
  parameter int unsigned FINE_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic              en,
  input logic              prd_wr,
  input logic [CNT_W-1:0]  prd_wdata,
  input logic [CNT_W-1:0]  ctr,
  input logic [CNT_W-1:0]  prd,
  input logic [CNT_W-1:0]  cmpa_sh,
  input logic [CNT_W-1:0]  cmpa_act,
  input logic              pwm_a,
  input logic              pwm_b,
  input logic [FINE_W-1:0] fine_code,
  input logic              fine_valid
);

  a_r1_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (en && ctr >= prd) |=> (ctr == '0));

  a_r1_step_up: assert property (@(posedge clk) disable iff (rst)
    (en && ctr < prd) |=> (ctr == CNT_W'($past(ctr) + 1'b1)));

  a_r2_prd_immediate: assert property (@(posedge clk) disable iff (rst)
    prd_wr |=> (prd == $past(prd_wdata)));

  a_r3_active_hold: assert property (@(posedge clk) disable iff (rst)
    !(en && ctr == '0) |=> $stable(cmpa_act));

  a_r3_active_load: assert property (@(posedge clk) disable iff (rst)
    (en && ctr == '0) |=> (cmpa_act == $past(cmpa_sh)));

  a_r4_rise_at_zero: assert property (@(posedge clk) disable iff (rst)
    (en && ctr == '0 && cmpa_sh != '0) |=> pwm_a);

  a_r6_fine_hold: assert property (@(posedge clk) disable iff (rst)
    !(en && ctr == '0) |=> $stable(fine_code));

  a_r7_valid_on_fall: assert property (@(posedge clk) disable iff (rst)
    fine_valid |-> ($past(pwm_a) && !pwm_a));

  a_r9_zero_cmp_low: assert property (@(posedge clk) disable iff (rst)
    (en && ctr == '0 && cmpa_sh == '0) |=> !pwm_a);

  a_r10_freeze: assert property (@(posedge clk) disable iff (rst)
    !en |=> ($stable(pwm_a) && $stable(pwm_b) && $stable(ctr) && !fine_valid));

endmodule

bind pwm_fine_edge_gen pwm_fine_edge_gen_chk #(
  .CNT_W  (CNT_W),
  .FINE_W (FINE_W)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .en         (en),
  .prd_wr     (prd_wr),
  .prd_wdata  (prd_wdata),
  .ctr        (ctr_q),
  .prd        (prd_q),
  .cmpa_sh    (cmp_sh[0]),
  .cmpa_act   (cmp_act[0]),
  .pwm_a      (pwm_a),
  .pwm_b      (pwm_b),
  .fine_code  (fine_code),
  .fine_valid (fine_valid)
);

// File: tb/pwm_fine_edge_gen_tb_top.sv
`timescale 1ns/1ps
module pwm_fine_edge_gen_tb_top;

  localparam int CNT_W  = 16;
  localparam int FINE_W = 8;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              en = 1'b0;
  logic              prd_wr = 1'b0;
  logic [CNT_W-1:0]  prd_wdata = '0;
  logic              cmpa_wr = 1'b0;
  logic [CNT_W-1:0]  cmpa_wdata = '0;
  logic              cmpb_wr = 1'b0;
  logic [CNT_W-1:0]  cmpb_wdata = '0;
  logic              fine_wr = 1'b0;
  logic [FINE_W-1:0] fine_wdata = '0;
  logic              pwm_a;
  logic              pwm_b;
  logic [FINE_W-1:0] fine_code;
  logic              fine_valid;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  pwm_fine_edge_gen #(
    .CNT_W       (CNT_W),
    .FINE_W      (FINE_W),
    .INIT_PERIOD (30)
  ) dut_i (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .prd_wr     (prd_wr),
    .prd_wdata  (prd_wdata),
    .cmpa_wr    (cmpa_wr),
    .cmpa_wdata (cmpa_wdata),
    .cmpb_wr    (cmpb_wr),
    .cmpb_wdata (cmpb_wdata),
    .fine_wr    (fine_wr),
    .fine_wdata (fine_wdata),
    .pwm_a      (pwm_a),
    .pwm_b      (pwm_b),
    .fine_code  (fine_code),
    .fine_valid (fine_valid)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // ---------------- behavioural reference model ----------------
  int m_ctr, m_prd, m_sha, m_shb, m_shf, m_acta, m_actb, m_actf;
  bit m_pa, m_pb, m_fv, m_live;

  always @(posedge clk) begin
    bit na, nb;
    if (rst) begin
      m_ctr = 0; m_prd = 29;
      m_sha = 15; m_shb = 15; m_shf = 1;
      m_acta = 15; m_actb = 15; m_actf = 1;
      m_pa = 0; m_pb = 0; m_fv = 0;
    end else begin
      m_fv = 0;
      if (en) begin
        if (m_ctr == 0) begin
          m_acta = m_sha; m_actb = m_shb; m_actf = m_shf;
          na = (m_acta != 0);
          nb = (m_actb != 0);
        end else begin
          na = (m_ctr == m_acta) ? 1'b0 : m_pa;
          nb = (m_ctr == m_actb) ? 1'b0 : m_pb;
        end
        m_fv = m_pa && !na;
        m_pa = na;
        m_pb = nb;
        m_ctr = (m_ctr >= m_prd) ? 0 : m_ctr + 1;
      end
      if (prd_wr)  m_prd = int'(prd_wdata);
      if (cmpa_wr) m_sha = int'(cmpa_wdata);
      if (cmpb_wr) m_shb = int'(cmpb_wdata);
      if (fine_wr) m_shf = int'(fine_wdata);
    end
    m_live = 1'b1;
  end

  // Compare every clock, half a period after the active edge.
  always @(negedge clk) begin
    if (m_live && !done) begin
      chk(pwm_a == m_pa, "R4", "model pwm_a", int'(pwm_a), int'(m_pa));
      chk(pwm_b == m_pb, "R5", "model pwm_b", int'(pwm_b), int'(m_pb));
      chk(int'(fine_code) == m_actf, "R6", "model fine_code", int'(fine_code), m_actf);
      chk(fine_valid == m_fv, "R7", "model fine_valid", int'(fine_valid), int'(m_fv));
    end
  end

  // ---------------- stimulus helpers (called at a falling edge) ----------------
  task automatic wr_prd(input int v);
    prd_wr = 1'b1; prd_wdata = CNT_W'(v);
    @(negedge clk); prd_wr = 1'b0;
  endtask
  task automatic wr_cmpa(input int v);
    cmpa_wr = 1'b1; cmpa_wdata = CNT_W'(v);
    @(negedge clk); cmpa_wr = 1'b0;
  endtask
  task automatic wr_cmpb(input int v);
    cmpb_wr = 1'b1; cmpb_wdata = CNT_W'(v);
    @(negedge clk); cmpb_wr = 1'b0;
  endtask
  task automatic wr_fine(input int v);
    fine_wr = 1'b1; fine_wdata = FINE_W'(v);
    @(negedge clk); fine_wr = 1'b0;
  endtask

  task automatic high_time(input int n, output int ha, output int hb);
    ha = 0; hb = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_a) ha++;
      if (pwm_b) hb++;
    end
  endtask

  task automatic wait_rise_a(input int limit, output int waited);
    bit prev;
    prev = pwm_a;
    waited = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      waited++;
      if (pwm_a && !prev) return;
      prev = pwm_a;
    end
    waited = -1;
  endtask

  initial begin
    int ha, hb, w, pulses, code_at;
    bit a0, b0;
    int f0;

    repeat (4) @(negedge clk);
    // R8: reset state, sampled while reset is still applied
    chk(pwm_a == 1'b0, "R8", "reset pwm_a", int'(pwm_a), 0);
    chk(pwm_b == 1'b0, "R8", "reset pwm_b", int'(pwm_b), 0);
    chk(fine_code == 8'd1, "R8", "reset fine_code", int'(fine_code), 1);
    chk(fine_valid == 1'b0, "R8", "reset fine_valid", int'(fine_valid), 0);
    rst = 1'b0;
    en  = 1'b1;
    repeat (40) @(negedge clk);

    // R4, R5: default 15 of 30
    high_time(30, ha, hb);
    chk(ha == 15, "R4", "default high A", ha, 15);
    chk(hb == 15, "R5", "default high B", hb, 15);

    // R1: rise-to-rise spacing equals terminal + 1
    wait_rise_a(100, w);
    wait_rise_a(100, w);
    chk(w == 30, "R1", "period clocks", w, 30);

    // R3: new compares take effect from a zero onward
    wr_cmpa(10);
    wr_cmpb(20);
    repeat (65) @(negedge clk);
    high_time(30, ha, hb);
    chk(ha == 10, "R3", "high A after shadow write", ha, 10);
    chk(hb == 20, "R5", "high B after shadow write", hb, 20);

    // R6: fine code written just after zero waits one full period
    wait_rise_a(100, w);
    wr_fine(8'h44);
    chk(fine_code == 8'd1, "R6", "fine code before zero", int'(fine_code), 1);
    wait_rise_a(100, w);
    chk(fine_code == 8'h44, "R6", "fine code after zero", int'(fine_code), 'h44);

    // R7: one pulse per period, carrying the active code
    pulses = 0; code_at = -1;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (fine_valid) begin
        pulses++;
        code_at = int'(fine_code);
      end
    end
    chk(pulses == 1, "R7", "pulses per period", pulses, 1);
    chk(code_at == 'h44, "R7", "code at pulse", code_at, 'h44);

    // R2: shrink terminal mid-period, counter already beyond it
    wr_prd(49);
    repeat (110) @(negedge clk);
    wait_rise_a(100, w);
    repeat (19) @(negedge clk);
    wr_prd(9);
    wait_rise_a(10, w);
    chk(w == 2, "R2", "clocks to wrap after terminal write", w, 2);

    // R9: compare above terminal -> high all period; compare 0 -> low, no pulse
    wr_cmpa(10);
    repeat (25) @(negedge clk);
    high_time(10, ha, hb);
    chk(ha == 10, "R9", "high A with compare > terminal", ha, 10);
    wr_cmpa(0);
    repeat (25) @(negedge clk);
    pulses = 0; ha = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (pwm_a) ha++;
      if (fine_valid) pulses++;
    end
    chk(ha == 0, "R9", "high A with compare 0", ha, 0);
    chk(pulses == 0, "R9", "pulses with compare 0", pulses, 0);

    // R10: disabled channel holds outputs and accepts no transfer
    wr_cmpb(4);
    repeat (3) @(negedge clk);
    en = 1'b0;
    @(negedge clk);
    a0 = pwm_a; b0 = pwm_b; f0 = int'(fine_code);
    wr_fine(8'h99);
    wr_cmpb(7);
    repeat (20) @(negedge clk);
    chk(pwm_b == b0, "R10", "pwm_b held", int'(pwm_b), int'(b0));
    chk(pwm_a == a0, "R10", "pwm_a held", int'(pwm_a), int'(a0));
    chk(int'(fine_code) == f0, "R10", "fine code held", int'(fine_code), f0);
    en = 1'b1;

    // Mixed traffic: writes at arbitrary counts, model compared each clock
    for (int i = 0; i < 3000; i++) begin
      en = ($urandom_range(0, 9) != 0);
      prd_wr  = ($urandom_range(0, 60) == 0);
      prd_wdata = CNT_W'($urandom_range(2, 40));
      cmpa_wr = ($urandom_range(0, 15) == 0);
      cmpa_wdata = CNT_W'($urandom_range(0, 45));
      cmpb_wr = ($urandom_range(0, 15) == 0);
      cmpb_wdata = CNT_W'($urandom_range(0, 45));
      fine_wr = ($urandom_range(0, 10) == 0);
      fine_wdata = FINE_W'($urandom_range(0, 255));
      @(negedge clk);
    end
    prd_wr = 1'b0; cmpa_wr = 1'b0; cmpb_wr = 1'b0; fine_wr = 1'b0;
    repeat (5) @(negedge clk);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog expired before scenario end");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule